// File: doc/BRIEF.md
# Command-Register I2C Byte Master

This block is an I2C master that moves one byte per software command. A host reaches it over a small register bus with an 8-bit data path and a 3-bit address. The host programs an SCL prescaler and loads a transmit byte. It then writes a single control word. That word says whether the engine sends or receives, whether to open the transfer with a start, whether to close it with a stop, and whether the master acknowledges a received byte.

The engine drives SCL and SDA as open-drain pins: an output-enable of 1 pulls the line low, and 0 releases it. It shifts the byte out or in, handles the acknowledge slot and then either parks the bus with SCL low or releases it with a stop. A status register and an optional interrupt tell the host that the byte has finished, so the host can issue the next command.

A typical register read is a sequence of commands. The host writes the device address, then the register index, then the device address again with a repeated start. It then reads the last byte with a NACK and a stop.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, and whenever no byte is in flight and the bus is not parked, both SCL and SDA are released. The status register at address 5 then reads busy (bit 0) = 0 and pending (bit 1) = 0.
- R2: A bus access is taken when cyc and stb are both high. It is answered by a one-cycle ack, and read data is valid during the ack cycle. The address map is: 0 prescaler low byte, 1 prescaler high byte, 2 control, 3 transmit byte, 4 receive byte, 5 status. Registers that can be written read back what was written.
- R3: The control word has these bits: 7 enable, 6 interrupt enable, 5 write, 4 read, 3 NACK, 2 stop, 1 start. A command runs only when enable is set together with write or read; if both are set, write wins. A control write made while the engine is busy changes nothing and is ignored.
- R4: A write command sends the transmit byte MSB first. It releases SDA in the acknowledge slot and stores the sampled slave bit in status bit 2 (1 = NACK).
- R5: A read command releases SDA for eight bits and stores them, MSB first, in the receive register. In the acknowledge slot the master drives SDA low when the NACK bit is 0 and leaves it released when the NACK bit is 1.
- R6: With the stop bit set, a stop condition (SDA rising while SCL is high) follows the acknowledge slot and the bus is released. Without it, the engine ends with SCL held low and the bus parked.
- R7: A write command opens with a start condition (SDA falling while SCL is high) when the bus is not parked. When the bus is parked, a start happens only if the start bit is set, and it is then a repeated start.
- R8: Within a byte, SDA changes only while SCL is low.
- R9: When a byte finishes (after its stop, if one was requested), status pending is set. The irq output equals pending AND the interrupt-enable bit of the last accepted control word. An accepted control write clears pending.
- R10: With prescaler value P, each bit lasts 4*(P+1) clocks and SCL is high for 2*(P+1) clocks of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cyc | input | 1 | Bus cycle valid |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | 1 = write access |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| irq | output | 1 | Byte-complete interrupt |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A wrong quarter or bit counter shows up on the pins within one SCL period. It appears as an SCL high time that differs from 2*(P+1) clocks, or as an SDA edge while SCL is high, which a bus monitor decodes as a spurious start or stop. A wrong shift register or direction flag corrupts the byte that the slave model logs, or the receive register, by the end of that command. A wrong pending or parked flag appears as an irq level, status value or missing stop condition as soon as the command completes.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
package i2cm_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_START, PH_BITS, PH_STOP} phase_e;

  typedef struct packed {
    logic wr;
    logic rd;
    logic nack;
    logic stop;
    logic start;
  } cmd_t;

  localparam int CB_EN    = 7;
  localparam int CB_IEN   = 6;
  localparam int CB_WR    = 5;
  localparam int CB_RD    = 4;
  localparam int CB_NACK  = 3;
  localparam int CB_STOP  = 2;
  localparam int CB_START = 1;

  localparam logic [2:0] A_PRE_LO = 3'd0;
  localparam logic [2:0] A_PRE_HI = 3'd1;
  localparam logic [2:0] A_CTRL   = 3'd2;
  localparam logic [2:0] A_TX     = 3'd3;
  localparam logic [2:0] A_RX     = 3'd4;
  localparam logic [2:0] A_STAT   = 3'd5;
endpackage

// File: rtl/i2cm_regs.sv
`timescale 1ns/1ps
module i2cm_regs import i2cm_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  input  logic          eng_busy,
  input  logic          eng_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_ack,
  output logic          go,
  output cmd_t          cmd,
  output logic [DW-1:0] tx_byte,
  output logic [PW-1:0] presc,
  output logic          irq,
  output logic          ctrl_acc
);
  logic [PW-1:0] pre_q, pre_d;
  logic [DW-1:0] tx_q, tx_d, ctrl_q, ctrl_d, rdat_q, rdat_d, status;
  logic          pend_q, pend_d, ack_q, go_q, go_d, req, wr, busy_all;

  assign req      = bus_cyc & bus_stb & ~ack_q;
  assign wr       = req & bus_we;
  assign busy_all = eng_busy | go_q;
  assign ctrl_acc = wr && (bus_addr == A_CTRL) && !busy_all;
  assign status   = {{(DW-3){1'b0}}, rx_ack, pend_q, busy_all};

  always_comb begin
    pre_d  = pre_q;
    tx_d   = tx_q;
    ctrl_d = ctrl_q;
    pend_d = pend_q;
    rdat_d = rdat_q;
    go_d   = ctrl_acc & bus_wdata[CB_EN] & (bus_wdata[CB_WR] | bus_wdata[CB_RD]);
    if (wr) begin
      case (bus_addr)
        A_PRE_LO: pre_d[DW-1:0]  = bus_wdata;
        A_PRE_HI: pre_d[PW-1:DW] = bus_wdata[PW-DW-1:0];
        A_TX:     tx_d           = bus_wdata;
        default:  ;
      endcase
    end
    if (ctrl_acc) begin
      ctrl_d = bus_wdata;
      pend_d = 1'b0;
    end
    if (eng_done) pend_d = 1'b1;
    if (req && !bus_we) begin
      case (bus_addr)
        A_PRE_LO: rdat_d = pre_q[DW-1:0];
        A_PRE_HI: rdat_d = pre_q[PW-1:DW];
        A_CTRL:   rdat_d = ctrl_q;
        A_TX:     rdat_d = tx_q;
        A_RX:     rdat_d = rx_byte;
        A_STAT:   rdat_d = status;
        default:  rdat_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tx_q   <= '0;
      ctrl_q <= '0;
      rdat_q <= '0;
      pend_q <= 1'b0;
      ack_q  <= 1'b0;
      go_q   <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      tx_q   <= tx_d;
      ctrl_q <= ctrl_d;
      rdat_q <= rdat_d;
      pend_q <= pend_d;
      ack_q  <= req;
      go_q   <= go_d;
    end
  end

  always_comb begin
    cmd.wr    = ctrl_q[CB_WR];
    cmd.rd    = ctrl_q[CB_RD] & ~ctrl_q[CB_WR];
    cmd.nack  = ctrl_q[CB_NACK];
    cmd.stop  = ctrl_q[CB_STOP];
    cmd.start = ctrl_q[CB_START];
  end

  assign go        = go_q;
  assign tx_byte   = tx_q;
  assign presc     = pre_q;
  assign bus_ack   = ack_q;
  assign bus_rdata = rdat_q;
  assign irq       = pend_q & ctrl_q[CB_IEN];
endmodule

// File: rtl/i2cm_tick.sv
`timescale 1ns/1ps
module i2cm_tick #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [PW-1:0] presc,
  output logic          tick
);
  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == presc);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (!run || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
module i2cm_seq import i2cm_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  cmd_t          cmd_i,
  input  logic [DW-1:0] tx_i,
  input  logic          tick_i,
  input  logic          sda_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          held_o,
  output logic          in_bits_o,
  output logic [DW-1:0] rx_o,
  output logic          rxack_o,
  output logic          scl_oe_o,
  output logic          sda_oe_o
);
  localparam int BCW = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST = BCW'(DW);

  phase_e         ph_q, ph_d;
  logic [1:0]     q_q, q_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [DW-1:0]  sh_q, sh_d, rx_q, rx_d;
  cmd_t           cmd_q, cmd_d;
  logic           held_q, held_d, rxack_q, rxack_d, done;
  logic           scl_q, scl_d, sda_q, sda_d;

  always_comb begin
    ph_d = ph_q; q_d = q_q; bit_d = bit_q; sh_d = sh_q; cmd_d = cmd_q;
    held_d = held_q; rx_d = rx_q; rxack_d = rxack_q; done = 1'b0;
    case (ph_q)
      PH_IDLE: if (go_i) begin
        ph_d  = (cmd_i.wr && (cmd_i.start || !held_q)) ? PH_START : PH_BITS;
        q_d   = '0;
        bit_d = '0;
        sh_d  = cmd_i.wr ? tx_i : '0;
        cmd_d = cmd_i;
      end
      PH_START: if (tick_i) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd3) begin
          ph_d   = PH_BITS;
          held_d = 1'b1;
        end
      end
      PH_BITS: if (tick_i) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd2) begin
          if (bit_q == LAST) begin
            if (cmd_q.wr) rxack_d = sda_i;
            if (cmd_q.rd) rx_d = sh_q;
          end else if (cmd_q.rd) begin
            sh_d = {sh_q[DW-2:0], sda_i};
          end
        end
        if (q_q == 2'd3) begin
          if (bit_q == LAST) begin
            if (cmd_q.stop) ph_d = PH_STOP;
            else begin
              ph_d = PH_IDLE;
              done = 1'b1;
            end
          end else begin
            bit_d = bit_q + 1'b1;
            if (cmd_q.wr) sh_d = {sh_q[DW-2:0], 1'b0};
          end
        end
      end
      PH_STOP: if (tick_i) begin
        q_d = q_q + 2'd1;
        if (q_q == 2'd3) begin
          ph_d   = PH_IDLE;
          held_d = 1'b0;
          done   = 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // pin levels per quarter; registered so the pads see no decode glitches
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    case (ph_q)
      PH_IDLE:  scl_d = held_q;
      PH_START: begin
        scl_d = (q_q == 2'd0) ? held_q : (q_q == 2'd3);
        sda_d = q_q[1];
      end
      PH_BITS:  begin
        scl_d = (q_q == 2'd0) || (q_q == 2'd3);
        sda_d = (bit_q == LAST) ? (cmd_q.rd && !cmd_q.nack) : (cmd_q.wr && !sh_q[DW-1]);
      end
      PH_STOP:  begin
        scl_d = (q_q == 2'd0);
        sda_d = !q_q[1];
      end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE; q_q <= '0; bit_q <= '0; sh_q <= '0; cmd_q <= '0;
      held_q <= 1'b0; rx_q <= '0; rxack_q <= 1'b0; scl_q <= 1'b0; sda_q <= 1'b0;
    end else begin
      ph_q <= ph_d; q_q <= q_d; bit_q <= bit_d; sh_q <= sh_d; cmd_q <= cmd_d;
      held_q <= held_d; rx_q <= rx_d; rxack_q <= rxack_d; scl_q <= scl_d; sda_q <= sda_d;
    end
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign in_bits_o = (ph_q == PH_BITS);
  assign done_o    = done;
  assign held_o    = held_q;
  assign rx_o      = rx_q;
  assign rxack_o   = rxack_q;
  assign scl_oe_o  = scl_q;
  assign sda_oe_o  = sda_q;
endmodule

// File: rtl/i2c_cmd_master.sv
`timescale 1ns/1ps
module i2c_cmd_master import i2cm_pkg::*; #(
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  output logic          irq,
  output logic          scl_oe,
  input  logic          sda_in,
  output logic          sda_oe
);
  logic          go, tick, eng_busy, eng_done, eng_held, eng_in_bits, rx_ack, ctrl_acc;
  cmd_t          cmd;
  logic [DW-1:0] tx_byte, rx_byte;
  logic [PW-1:0] presc;

  i2cm_regs #(.DW(DW), .AW(AW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .eng_busy(eng_busy), .eng_done(eng_done), .rx_byte(rx_byte), .rx_ack(rx_ack),
    .go(go), .cmd(cmd), .tx_byte(tx_byte), .presc(presc), .irq(irq), .ctrl_acc(ctrl_acc)
  );

  i2cm_tick #(.PW(PW)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .presc(presc), .tick(tick)
  );

  i2cm_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_i(go), .cmd_i(cmd), .tx_i(tx_byte), .tick_i(tick),
    .sda_i(sda_in), .busy_o(eng_busy), .done_o(eng_done), .held_o(eng_held),
    .in_bits_o(eng_in_bits), .rx_o(rx_byte), .rxack_o(rx_ack),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );
endmodule

// File: rtl/i2cm_chk.sv
`timescale 1ns/1ps
module i2cm_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_ack,
  input logic irq,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic held,
  input logic in_bits,
  input logic done,
  input logic ctrl_acc
);
  p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !held) |-> (!scl_oe && !sda_oe));

  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_parked_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && held) |-> scl_oe);

  p_sda_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_bits) && $past(in_bits, 2) && !scl_oe && !$past(scl_oe)) |-> (sda_oe == $past(sda_oe)));

  p_irq_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc |=> !irq);
endmodule

bind i2c_cmd_master i2cm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ack(bus_ack), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(eng_busy), .held(eng_held), .in_bits(eng_in_bits), .done(eng_done), .ctrl_acc(ctrl_acc)
);

// File: tb/i2c_cmd_master_tb_top.sv
`timescale 1ns/1ps
module i2c_cmd_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic ack, irq, scl_oe, sda_oe;
  logic scl_w, sda_w, slv_low;

  int n_chk = 0, n_fail = 0;
  int log_q[$];
  int exp_q[$];
  int cur_presc = 0;
  bit finished = 0;

  // slave model state
  bit slv_tx = 0, slv_ack_en = 1;
  logic [7:0] slv_txb = 8'h00;
  int s_bit = 0, hi_cnt = 0;
  bit s_skip = 0, s_nacked = 0, rose = 0;
  logic [7:0] s_sh = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  always #2 clk = ~clk;

  assign scl_w = !scl_oe;
  assign sda_w = !(sda_oe || slv_low);

  always_comb begin
    slv_low = 1'b0;
    if (slv_tx) begin
      if (s_bit < 8 && !s_nacked && !s_skip) slv_low = !slv_txb[7 - s_bit];
    end else if (s_bit == 8 && slv_ack_en) begin
      slv_low = 1'b1;
    end
  end

  i2c_cmd_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cyc(cyc), .bus_stb(stb), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ack(ack),
    .irq(irq), .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus-level monitor and slave, evaluated every clock away from the edge (R8, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_w && p_sda && !sda_w) begin
        log_q.push_back(1000); s_bit = 0; s_skip = 1; s_nacked = 0;
      end else if (p_scl && scl_w && !p_sda && sda_w) begin
        log_q.push_back(1001); rose = 0;
      end else if (!p_scl && scl_w) begin
        if (s_bit < 8) s_sh = {s_sh[6:0], sda_w};
        else begin
          log_q.push_back(int'({sda_w, s_sh}));
          if (slv_tx && sda_w) s_nacked = 1;
        end
        rose = 1; hi_cnt = 0;
      end else if (p_scl && !scl_w) begin
        if (rose) check(hi_cnt == 2 * (cur_presc + 1), "R10 scl high clocks", hi_cnt, 2 * (cur_presc + 1));
        rose = 0;
        if (s_skip) s_skip = 0;
        else s_bit = (s_bit == 8) ? 0 : s_bit + 1;
      end
      if (scl_w) hi_cnt++;
      p_scl = scl_w; p_sda = sda_w;
    end
  end

  task automatic bwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); while (!ack) @(negedge clk);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic brd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cyc = 1; stb = 1; we = 0; addr = a;
    @(negedge clk); while (!ack) @(negedge clk);
    d = rdata; cyc = 0; stb = 0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    do brd(3'd5, s); while (s[0]);
    repeat (4) @(negedge clk);
  endtask

  task automatic cmp_log(input string req);
    check(log_q.size() == exp_q.size(), {req, " event count"}, log_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
      check(log_q[i] == exp_q[i], {req, " bus event"}, log_q[i], exp_q[i]);
    log_q.delete(); exp_q.delete();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl_w && sda_w, "R1 lines released after reset", {scl_w, sda_w}, 3);
    check(irq == 0, "R1 irq after reset", irq, 0);
    brd(3'd5, v); check(v == 8'h00, "R1 status after reset", v, 0);
    brd(3'd4, v); check(v == 8'h00, "R2 rx after reset", v, 0);

    // R2 prescaler registers
    bwr(3'd1, 8'h00); bwr(3'd0, 8'h01); cur_presc = 1;
    brd(3'd0, v); check(v == 8'h01, "R2 prescaler low readback", v, 1);
    brd(3'd1, v); check(v == 8'h00, "R2 prescaler high readback", v, 0);

    // R4 R7 write from idle bus: auto start
    bwr(3'd3, 8'hA6); bwr(3'd2, 8'hE0); wait_idle();
    exp_q.push_back(1000); exp_q.push_back('h0A6); cmp_log("R4 R7 write from idle");
    brd(3'd5, v); check(v == 8'h02, "R9 status after byte", v, 2);
    check(irq == 1, "R9 irq raised", irq, 1);
    check(!scl_w, "R6 bus parked with scl low", scl_w, 0);

    // R9 clear; R7 parked write without start bit: no start
    bwr(3'd3, 8'h3C); bwr(3'd2, 8'hE0);
    check(irq == 0, "R9 irq cleared by control write", irq, 0);
    wait_idle();
    exp_q.push_back('h03C); cmp_log("R7 parked write no start");

    // R7 repeated start
    bwr(3'd3, 8'hA7); bwr(3'd2, 8'hE2); wait_idle();
    exp_q.push_back(1000); exp_q.push_back('h0A7); cmp_log("R7 repeated start");

    // R5 read with master ACK
    slv_tx = 1; slv_txb = 8'h5C;
    bwr(3'd2, 8'hD0); wait_idle();
    exp_q.push_back('h05C); cmp_log("R5 read with ACK");
    brd(3'd4, v); check(v == 8'h5C, "R5 rx byte", v, 'h5C);

    // R5 R6 read last byte with NACK and stop
    slv_txb = 8'hC3;
    bwr(3'd2, 8'hDC); wait_idle();
    exp_q.push_back('h1C3); exp_q.push_back(1001); cmp_log("R5 R6 read NACK stop");
    brd(3'd4, v); check(v == 8'hC3, "R5 rx byte last", v, 'hC3);
    check(scl_w && sda_w, "R6 lines released after stop", {scl_w, sda_w}, 3);

    // R4 slave NACK on write, interrupt disabled
    slv_tx = 0; slv_ack_en = 0;
    bwr(3'd3, 8'h81); bwr(3'd2, 8'hA4); wait_idle();
    exp_q.push_back(1000); exp_q.push_back('h181); exp_q.push_back(1001); cmp_log("R4 slave NACK");
    brd(3'd5, v); check(v == 8'h06, "R4 R9 status NACK pending", v, 6);
    check(irq == 0, "R9 irq masked by ien", irq, 0);

    // R3 enable clear: no transfer
    slv_ack_en = 1;
    bwr(3'd2, 8'h20);
    repeat (40) @(negedge clk);
    brd(3'd5, v); check(v[0] == 0, "R3 disabled command stays idle", v[0], 0);
    check(v[1] == 0, "R9 accepted write clears pending", v[1], 0);
    check(scl_w && sda_w, "R3 lines idle", {scl_w, sda_w}, 3);
    cmp_log("R3 disabled command");

    // R3 command during busy ignored
    bwr(3'd3, 8'h11); bwr(3'd2, 8'hE4); bwr(3'd2, 8'hE0);
    brd(3'd2, v); check(v == 8'hE4, "R3 busy control write ignored", v, 'hE4);
    wait_idle();
    exp_q.push_back(1000); exp_q.push_back('h011); exp_q.push_back(1001); cmp_log("R3 busy write ignored");
    brd(3'd5, v); check(v == 8'h02, "R3 status after ignored write", v, 2);

    // R10 slower prescaler
    bwr(3'd0, 8'h05); cur_presc = 5;
    bwr(3'd3, 8'h96); bwr(3'd2, 8'hE4); wait_idle();
    exp_q.push_back(1000); exp_q.push_back('h096); exp_q.push_back(1001); cmp_log("R10 prescaler 5");

    finished = 1;
    summary();
    $finish;
  end
endmodule